// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block runs one Serial Wire Debug register access at a time, read or write, towards a debug target. It generates the serial clock, drives the request and write-data phases on a tri-state data line, releases the line for the turnaround and acknowledge phases, and samples read data. At the end it reports a status and, for reads, the 32-bit word. Handling retries, line resets and register meaning is left to the controller above it.

The bit period comes from a half-period count held in the block. Software loads a target frequency and the block turns it into a half-period count of system clocks. A controller issues a command with a one-cycle start pulse, waits for the one-cycle completion pulse, and then reads the status, the raw acknowledge bits and the read word.

Top module: `swd_host_engine`

## Requirements
- R1: Each transaction starts with 8 driven request bits, bit 0 first: bit 0 = 1, bit 1 = port select (1 = access port), bit 2 = direction (1 = read), bits 3 and 4 = address bits 0 and 1, bit 5 = XOR of bits 1 to 4, bit 6 = 0, bit 7 = 1.
- R2: After the request the host samples 5 bits: a turnaround bit, then 3 acknowledge bits (first bit lands in `ack_raw[0]`), then a fifth bit. Status codes are 0 = OK (ack 3'b001), 1 = WAIT (3'b010), 2 = FAULT (3'b100), 3 = unknown (any other ack value), 4 = bad read parity. `ack_raw` always returns the three captured bits.
- R3: A transaction whose acknowledge is not OK ends after 13 bit periods in total, and `rdata` reads 0.
- R4: A read with an OK acknowledge takes 32 data bits, first bit into `rdata[0]`, then a parity bit, then one turnaround: 46 bit periods in total.
- R5: When the received parity bit differs from the XOR of the 32 read data bits, the status is 4, and `rdata` still shows the received word.
- R6: During a write, all 5 bits after the request are inputs. If the acknowledge is not OK, no data is driven.
- R7: A write with an OK acknowledge drives 32 data bits, bit 0 first, then their XOR parity bit: 46 bit periods in total.
- R8: Every bit period is `swclk` low for H system clocks, then high for H. Driven data changes only when `swclk` falls. Input data is sampled in the last low cycle. After the last bit `swclk` stays high for H cycles before `done` rises.
- R9: Loading a frequency F sets H = ceil(floor(SYS_HZ/2)/F), with a minimum of 1 and a ceiling of 2^HALF_W-1. After reset H = RST_HALF.
- R10: A frequency load with F = 0 is rejected. A load is also ignored while busy, or in the same cycle as a start pulse. In every such case H is unchanged.
- R11: `cmd_start` is accepted only when idle, and `busy` rises in the next cycle. A start pulse while busy has no effect. `done` is a one-cycle pulse that comes with the final status, in the same cycle that `busy` falls.
- R12: `swdio_oe` is high only during request and write-data/parity bits. When idle, `swclk` = 1, `swdio_oe` = 0 and `swdio_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freq_load | input | 1 | Load a new target bit frequency |
| freq_hz | input | 32 | Target frequency in Hz for a load |
| cmd_start | input | 1 | Start pulse for one transaction |
| cmd_ap | input | 1 | Port select: 1 = access port, 0 = debug port |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 2 | Register address bits |
| cmd_wdata | input | 32 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Result code, valid with done |
| ack_raw | output | 3 | Captured acknowledge bits, valid with done |
| rdata | output | 32 | Read word, valid with done |
| swclk | output | 1 | Serial clock to target |
| swdio_o | output | 1 | Data line output value |
| swdio_oe | output | 1 | Data line output enable |
| swdio_i | input | 1 | Data line input value |

## Verification
The bench builds the engine with a 100 MHz system clock figure and HALF_W = 4. This lowers the half-period ceiling to 15, so the saturation case (a 1 Hz load) finishes in about 1,400 cycles. A behavioural target watches `swclk`, returns chosen acknowledges, data and corrupted parity, and measures every low and high phase against the expected H. Because H values of 1, 2, 3, 5 and 15 all occur, off-by-one errors in the phase counter and the rounding of the divider become visible.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  typedef enum logic [2:0] {
    ST_OK          = 3'd0,
    ST_WAIT        = 3'd1,
    ST_FAULT       = 3'd2,
    ST_ACK_UNKNOWN = 3'd3,
    ST_BAD_PARITY  = 3'd4
  } swd_status_e;

  localparam int REQ_BITS      = 8;
  localparam int ACK_FIRST     = 9;
  localparam int ACK_LAST      = 11;
  localparam int SHORT_BITS    = 13;
  localparam int RD_DATA_FIRST = 12;
  localparam int RD_DATA_LAST  = 43;
  localparam int RD_PAR_BIT    = 44;
  localparam int WR_DATA_FIRST = 13;
  localparam int FULL_BITS     = 46;

  localparam logic [2:0] ACK_CODE_OK    = 3'b001;
  localparam logic [2:0] ACK_CODE_WAIT  = 3'b010;
  localparam logic [2:0] ACK_CODE_FAULT = 3'b100;

  function automatic logic even_par32(input logic [31:0] v);
    return ^v;
  endfunction

  // request byte, bit 0 is shifted first
  function automatic logic [7:0] req_byte(input logic ap, input logic rnw,
                                          input logic [1:0] addr);
    logic [7:0] r;
    r[0] = 1'b1;
    r[1] = ap;
    r[2] = rnw;
    r[4:3] = addr;
    r[5] = ap ^ rnw ^ addr[0] ^ addr[1];
    r[6] = 1'b0;
    r[7] = 1'b1;
    return r;
  endfunction

  function automatic swd_status_e decode_ack(input logic [2:0] ack);
    case (ack)
      ACK_CODE_OK:    return ST_OK;
      ACK_CODE_WAIT:  return ST_WAIT;
      ACK_CODE_FAULT: return ST_FAULT;
      default:        return ST_ACK_UNKNOWN;
    endcase
  endfunction

  // ceil((sys/2)/f), at least 1; caller guarantees f != 0
  function automatic logic [31:0] half_from_freq(input logic [31:0] sys_hz,
                                                 input logic [31:0] f_hz);
    logic [63:0] num;
    logic [63:0] den;
    logic [63:0] q;
    den = {32'd0, f_hz};
    num = {32'd0, sys_hz >> 1} + den - 64'd1;
    q = num / den;
    if (q == 64'd0) q = 64'd1;
    return q[31:0];
  endfunction

endpackage

// File: rtl/swd_half_period.sv
module swd_half_period #(
  parameter int unsigned SYS_HZ   = 100_000_000,
  parameter int          HALF_W   = 16,
  parameter int          RST_HALF = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [31:0]       freq_hz,
  input  logic              allow,
  output logic [HALF_W-1:0] half
);
  localparam logic [31:0] HALF_MAX = (32'd1 << HALF_W) - 32'd1;

  logic [HALF_W-1:0] half_q;
  logic [31:0]       raw;
  logic [HALF_W-1:0] clipped;
  logic              load_ok;

  always_comb begin
    raw = swd_host_pkg::half_from_freq(32'(SYS_HZ), freq_hz);
    if (raw > HALF_MAX) clipped = '1;
    else                clipped = raw[HALF_W-1:0];
    load_ok = load && allow && (freq_hz != 32'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half_q <= HALF_W'(RST_HALF);
    else if (load_ok) half_q <= clipped;
  end

  assign half = half_q;

  p_zero_rejected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && freq_hz == 32'd0) |=> $stable(half_q));

  p_half_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    half_q != '0);

endmodule

// File: rtl/swd_bit_clock.sv
module swd_bit_clock #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              stop,
  input  logic [HALF_W-1:0] half,
  output logic              swclk,
  output logic              boundary,
  output logic              sample
);
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] lim;
  logic              swclk_q;
  logic              phase_end;

  always_comb begin
    lim       = half - HALF_W'(1);
    phase_end = run && (cnt == lim);
    boundary  = phase_end && swclk_q;
    sample    = phase_end && !swclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swclk_q <= 1'b1;
      cnt     <= '0;
    end else if (!run) begin
      swclk_q <= 1'b1;
      cnt     <= lim;   // first bit starts at once when run rises
    end else if (cnt == lim) begin
      cnt <= '0;
      if (!swclk_q)   swclk_q <= 1'b1;
      else if (!stop) swclk_q <= 1'b0;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end

  assign swclk = swclk_q;

  p_rise_after_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> swclk_q);

  p_stop_holds_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && stop) |=> swclk_q);

endmodule

// File: rtl/swd_txn_seq.sv
module swd_txn_seq
  import swd_host_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic        cmd_ap,
  input  logic        cmd_read,
  input  logic [1:0]  cmd_addr,
  input  logic [31:0] cmd_wdata,
  input  logic        boundary,
  input  logic        sample,
  input  logic        swdio_i,
  output logic        busy,
  output logic        stop,
  output logic        done,
  output logic [2:0]  status,
  output logic [2:0]  ack_raw,
  output logic [31:0] rdata,
  output logic        swdio_o,
  output logic        swdio_oe
);
  logic        busy_q, done_q, ap_q, rd_q, rxpar_q, dout_q, oe_q;
  logic [5:0]  idx_q;
  logic [1:0]  addr_q;
  logic [31:0] wdata_q, rx_q, rdata_q;
  logic [2:0]  ack_q, ackraw_q;
  swd_status_e status_q;

  logic        accept, ack_ok, finish, advance, drv_oe, drv_val;
  logic [5:0]  cur;
  logic [7:0]  req;
  logic [4:0]  widx;
  swd_status_e fin_status;

  always_comb begin
    accept  = cmd_start && !busy_q;
    ack_ok  = (ack_q == ACK_CODE_OK);
    finish  = busy_q && boundary &&
              ((idx_q == 6'(FULL_BITS)) || ((idx_q == 6'(SHORT_BITS)) && !ack_ok));
    advance = busy_q && boundary && !finish;
    cur     = idx_q - 6'd1;
    req     = req_byte(ap_q, rd_q, addr_q);
    widx    = 5'(idx_q - 6'(WR_DATA_FIRST));
    drv_oe  = (idx_q < 6'(REQ_BITS)) || (!rd_q && (idx_q >= 6'(WR_DATA_FIRST)));
    if (idx_q < 6'(REQ_BITS))             drv_val = req[idx_q[2:0]];
    else if (!drv_oe)                     drv_val = 1'b1;
    else if (idx_q == 6'(FULL_BITS - 1))  drv_val = even_par32(wdata_q);
    else                                  drv_val = wdata_q[widx];
    fin_status = decode_ack(ack_q);
    if (ack_ok && rd_q && (rxpar_q != even_par32(rx_q))) fin_status = ST_BAD_PARITY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      ap_q     <= 1'b0;
      rd_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      ack_q    <= '0;
      rx_q     <= '0;
      rxpar_q  <= 1'b0;
      status_q <= ST_OK;
      ackraw_q <= '0;
      rdata_q  <= '0;
      dout_q   <= 1'b1;
      oe_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        ap_q    <= cmd_ap;
        rd_q    <= cmd_read;
        addr_q  <= cmd_addr;
        wdata_q <= cmd_wdata;
        ack_q   <= '0;
      end
      if (busy_q && sample) begin
        if (cur >= 6'(ACK_FIRST) && cur <= 6'(ACK_LAST))
          ack_q[2'(cur - 6'(ACK_FIRST))] <= swdio_i;
        if (rd_q && cur >= 6'(RD_DATA_FIRST) && cur <= 6'(RD_DATA_LAST))
          rx_q <= {swdio_i, rx_q[31:1]};
        if (rd_q && cur == 6'(RD_PAR_BIT))
          rxpar_q <= swdio_i;
      end
      if (advance) begin
        idx_q  <= idx_q + 6'd1;
        oe_q   <= drv_oe;
        dout_q <= drv_val;
      end
      if (finish) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        oe_q     <= 1'b0;
        dout_q   <= 1'b1;
        status_q <= fin_status;
        ackraw_q <= ack_q;
        rdata_q  <= (rd_q && ack_ok) ? rx_q : 32'd0;
      end
    end
  end

  assign busy     = busy_q;
  assign stop     = finish;
  assign done     = done_q;
  assign status   = status_q;
  assign ack_raw  = ackraw_q;
  assign rdata    = rdata_q;
  assign swdio_o  = dout_q;
  assign swdio_oe = oe_q;

  p_oe_only_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> busy_q);

  p_idle_park_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> dout_q);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $fell(busy_q));

  p_status_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (status_q <= ST_BAD_PARITY));

  p_boundary_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (idx_q >= 6'(SHORT_BITS)));

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine #(
  parameter int unsigned SYS_HZ   = 100_000_000,
  parameter int          HALF_W   = 16,
  parameter int          RST_HALF = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        freq_load,
  input  logic [31:0] freq_hz,
  input  logic        cmd_start,
  input  logic        cmd_ap,
  input  logic        cmd_read,
  input  logic [1:0]  cmd_addr,
  input  logic [31:0] cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic [2:0]  status,
  output logic [2:0]  ack_raw,
  output logic [31:0] rdata,
  output logic        swclk,
  output logic        swdio_o,
  output logic        swdio_oe,
  input  logic        swdio_i
);
  logic [HALF_W-1:0] half;
  logic              boundary, sample, stop, busy_w, swclk_w;
  logic              load_allow;

  assign load_allow = !busy_w && !cmd_start;

  swd_half_period #(.SYS_HZ(SYS_HZ), .HALF_W(HALF_W), .RST_HALF(RST_HALF)) u_half (
    .clk(clk), .rst_n(rst_n), .load(freq_load), .freq_hz(freq_hz),
    .allow(load_allow), .half(half)
  );

  swd_bit_clock #(.HALF_W(HALF_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .stop(stop), .half(half),
    .swclk(swclk_w), .boundary(boundary), .sample(sample)
  );

  swd_txn_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_ap(cmd_ap),
    .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .boundary(boundary), .sample(sample), .swdio_i(swdio_i),
    .busy(busy_w), .stop(stop), .done(done), .status(status),
    .ack_raw(ack_raw), .rdata(rdata), .swdio_o(swdio_o), .swdio_oe(swdio_oe)
  );

  assign busy  = busy_w;
  assign swclk = swclk_w;

  p_idle_clk_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> swclk_w);

  p_half_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |=> $stable(half));

endmodule

// File: tb/sim_swd_host_engine.sv
module sim_swd_host_engine;
  localparam int unsigned SYS_HZ = 100_000_000;
  localparam int HALF_W = 4;
  localparam int HMAX = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic freq_load = 1'b0;
  logic [31:0] freq_hz = '0;
  logic cmd_start = 1'b0, cmd_ap = 1'b0, cmd_read = 1'b0;
  logic [1:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic swdio_i = 1'b1;
  logic busy, done, swclk, swdio_o, swdio_oe;
  logic [2:0] status, ack_raw;
  logic [31:0] rdata;

  int n_chk = 0, n_fail = 0;
  int exp_half = 1;
  bit finished = 0;

  always #5 clk = ~clk;

  swd_host_engine #(.SYS_HZ(SYS_HZ), .HALF_W(HALF_W), .RST_HALF(1)) u0 (
    .clk(clk), .rst_n(rst_n), .freq_load(freq_load), .freq_hz(freq_hz),
    .cmd_start(cmd_start), .cmd_ap(cmd_ap), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .status(status), .ack_raw(ack_raw), .rdata(rdata), .swclk(swclk),
    .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int model_half(input longint f);
    longint base = SYS_HZ / 2;
    longint q = base / f;
    if (q * f < base) q++;
    if (q < 1) q = 1;
    if (q > HMAX) q = HMAX;
    return int'(q);
  endfunction

  function automatic logic [7:0] model_req(input logic ap, input logic rd, input logic [1:0] a);
    logic [7:0] r;
    r = 8'b1000_0001;
    r[1] = ap; r[2] = rd; r[3] = a[0]; r[4] = a[1];
    r[5] = (ap + rd + a[0] + a[1]) % 2;
    return r;
  endfunction

  function automatic int model_status(input logic [2:0] ack, input logic rd, input bit badp);
    if (ack == 3'b001) return (rd && badp) ? 4 : 0;
    if (ack == 3'b010) return 1;
    if (ack == 3'b100) return 2;
    return 3;
  endfunction

  task automatic set_freq(input logic [31:0] f);
    @(negedge clk);
    freq_hz = f; freq_load = 1'b1;
    @(negedge clk);
    freq_load = 1'b0;
    if (f != 0) exp_half = model_half(longint'(f));
  endtask

  // side: 0 none, 1 start pulse mid-way, 2 load mid-way, 3 load together with start
  task automatic run_txn(input logic ap, input logic rd, input logic [1:0] a,
                         input logic [31:0] wd, input logic [2:0] tack,
                         input logic [31:0] trd, input bit badp, input int side);
    logic [7:0] reqcap = '0;
    logic [31:0] wcap = '0;
    int nbits = 0, cyc = 0, t_edge = 0, tim_err = 0, oe_err = 0, drv_err = 0;
    bit prev = 1'b1, prev_busy = 1'b1, prev_o, injected = 0, ok_ack;
    int exp_bits;
    ok_ack = (tack == 3'b001);
    exp_bits = ok_ack ? 46 : 13;
    @(negedge clk);
    cmd_ap = ap; cmd_read = rd; cmd_addr = a; cmd_wdata = wd; cmd_start = 1'b1;
    if (side == 3) begin freq_hz = 32'd1; freq_load = 1'b1; end
    @(negedge clk);
    cmd_start = 1'b0; freq_load = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    prev_o = swdio_o;
    while (1) begin
      @(negedge clk);
      cyc++;
      cmd_start = 1'b0; freq_load = 1'b0;
      if (!prev && swclk) begin // rise: bit nbits was sampled
        if (cyc - t_edge != exp_half) tim_err++;
        if (nbits < 8) begin
          reqcap[nbits] = swdio_o;
          if (!swdio_oe) oe_err++;
        end else if (!rd && ok_ack && nbits >= 13) begin
          if (nbits < 45) wcap[nbits-13] = swdio_o;
          else if (swdio_o != ^wd) drv_err++;
          if (!swdio_oe) oe_err++;
        end else if (swdio_oe) oe_err++;
        t_edge = cyc;
        nbits++;
      end
      if (prev && !swclk) begin // fall: bit nbits starts
        if (nbits > 0 && cyc - t_edge != exp_half) tim_err++;
        t_edge = cyc;
        if (nbits == 8) swdio_i = 1'b1;
        else if (nbits >= 9 && nbits <= 11) swdio_i = tack[nbits-9];
        else if (rd && ok_ack && nbits >= 12 && nbits <= 43) swdio_i = trd[nbits-12];
        else if (rd && ok_ack && nbits == 44) swdio_i = (^trd) ^ badp;
        else swdio_i = 1'b1;
      end else if (busy && prev_busy && swdio_o != prev_o) drv_err++;
      if (!injected && nbits == 20 && side == 1) begin
        injected = 1; cmd_start = 1'b1; cmd_read = ~rd; cmd_addr = ~a;
      end
      if (!injected && nbits == 20 && side == 2) begin
        injected = 1; freq_hz = 32'd1; freq_load = 1'b1;
      end
      prev = swclk; prev_busy = busy; prev_o = swdio_o;
      if (done) break;
      if (cyc > 5000) break;
    end
    chk(done == 1'b1 && busy == 1'b0, "R11 done with busy low", {done, busy}, 2'b10);
    chk(cyc - t_edge == exp_half, "R8 last high phase", cyc - t_edge, exp_half);
    chk(tim_err == 0, "R8 phase lengths", tim_err, 0);
    chk(drv_err == 0, "R7 R8 data only changes at fall", drv_err, 0);
    chk(oe_err == 0, "R12 R6 output enable per phase", oe_err, 0);
    chk(nbits == exp_bits, ok_ack ? "R4 R7 bit count" : "R3 R6 bit count", nbits, exp_bits);
    chk(reqcap == model_req(ap, rd, a), "R1 request byte", reqcap, model_req(ap, rd, a));
    chk(int'(status) == model_status(tack, rd, badp), badp ? "R5 status" : "R2 status",
        status, model_status(tack, rd, badp));
    chk(ack_raw == tack, "R2 ack_raw", ack_raw, tack);
    if (rd && ok_ack) chk(rdata == trd, "R4 R5 read data", rdata, trd);
    else chk(rdata == 32'd0, "R3 rdata zero", rdata, 0);
    if (!rd && ok_ack) chk(wcap == wd, "R7 write data", wcap, wd);
    @(negedge clk);
    chk(done == 1'b0, "R11 done single pulse", done, 0);
    chk(busy == 1'b0 && swclk && !swdio_oe && swdio_o, "R12 R11 idle after done",
        {busy, swclk, swdio_oe, swdio_o}, 4'b0101);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    int list_f[4];
    list_f = '{50_000_000, 25_000_000, 20_000_000, 10_000_000};
    seed_init = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(swclk && !swdio_oe && swdio_o && !busy && !done, "R12 reset state",
        {swclk, swdio_oe, swdio_o, busy, done}, 5'b10100);

    // directed: reset divider, each ack kind, both directions
    run_txn(1'b0, 1'b1, 2'b00, 32'h0, 3'b001, 32'h2BA0_1477, 0, 0);   // R9 reset H=1, R4
    run_txn(1'b1, 1'b0, 2'b11, 32'hDEAD_BEEF, 3'b001, 32'h0, 0, 0);   // R7
    run_txn(1'b1, 1'b1, 2'b01, 32'h0, 3'b010, 32'h0, 0, 0);           // R3 WAIT read
    run_txn(1'b0, 1'b0, 2'b10, 32'h1234_5678, 3'b100, 32'h0, 0, 0);   // R6 FAULT write
    run_txn(1'b0, 1'b1, 2'b11, 32'h0, 3'b111, 32'h0, 0, 0);           // R2 unknown
    run_txn(1'b1, 1'b1, 2'b10, 32'h0, 3'b001, 32'h8000_0001, 1, 0);   // R5 bad parity

    // R9 rounding: 20 MHz -> ceil(2.5) = 3, 30 MHz -> 2
    set_freq(32'd20_000_000);
    chk(exp_half == 3, "R9 model 20MHz", exp_half, 3);
    run_txn(1'b0, 1'b0, 2'b01, 32'hA5A5_0F0F, 3'b001, 32'h0, 0, 0);
    set_freq(32'd30_000_000);
    run_txn(1'b0, 1'b1, 2'b00, 32'h0, 3'b001, 32'h0000_FFFF, 0, 0);
    // R10 zero frequency rejected: H stays 2
    set_freq(32'd0);
    run_txn(1'b1, 1'b1, 2'b01, 32'h0, 3'b001, 32'h7777_1111, 0, 0);
    // R10 load while busy and load with start ignored
    run_txn(1'b0, 1'b0, 2'b00, 32'h0BAD_F00D, 3'b001, 32'h0, 0, 2);
    run_txn(1'b0, 1'b1, 2'b10, 32'h0, 3'b001, 32'h0F0F_F0F0, 0, 3);
    // R11 start while busy ignored
    run_txn(1'b1, 1'b0, 2'b01, 32'hFFFF_FFFF, 3'b001, 32'h0, 0, 1);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R11 no second transaction", busy, 0);
    // R9 saturation at 2^HALF_W-1 and fastest rate
    set_freq(32'd1);
    run_txn(1'b0, 1'b1, 2'b01, 32'h0, 3'b001, 32'hC001_D00D, 0, 0);
    set_freq(32'd200_000_000);
    run_txn(1'b1, 1'b0, 2'b10, 32'h0000_0001, 3'b010, 32'h0, 0, 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      int r;
      logic [2:0] a3;
      bit bp;
      logic rdb;
      set_freq(32'(list_f[$urandom % 4]));
      r = int'($urandom % 10);
      bp = 0;
      rdb = 1'($urandom);
      if (r < 6) a3 = 3'b001;
      else if (r == 6) a3 = 3'b010;
      else if (r == 7) a3 = 3'b100;
      else if (r == 8) a3 = 3'($urandom % 2 == 0 ? 3'b000 : 3'b110);
      else begin a3 = 3'b001; bp = 1; rdb = 1'b1; end
      run_txn(1'($urandom), rdb, 2'($urandom), $urandom, a3, $urandom, bp, 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule